// File: doc/BRIEF.md
# Level-Sense Pin Detector with Sticky Latch

This block watches a port of general-purpose input pads and reports when any of them sits at a level chosen by software. Every pad is first passed through a two-flop synchronizer. For each pin, software picks one of three settings: watch for a high level, watch for a low level, or ignore the pin. Software can also disconnect the pin's input path. A pin whose synchronized value matches its chosen level raises its own detect line. Once that line has been high, it cannot fire again until the input has stayed at the opposite level for three clocks in a row.

A sticky latch keeps a record of every pin whose detect has been high. Software clears latch bits by writing ones to them, but a bit whose detect is still active stays set. The summary of the latch (high while any bit is set) is called the latched detect. If a clear write leaves any bit standing, the latched detect drops for exactly one clock and then rises again, so that an edge-triggered consumer sees a new event. A mode bit selects what drives the single port-level `detect_o`: either the OR of the live per-pin detects, or the latched detect.

Registers are reached through a single-cycle write strobe and a combinational read port. Address 0 holds the synchronized inputs (read-only), address 1 holds the latch (write one to clear), and address 2 holds the mode in bit 0. A set top address bit selects a pin configuration word, and the low bits give the pin index.

Top module: `lvl_sense_port`

## Requirements
- R1: After reset every latch bit is 0, the mode bit is 0 and `detect_o` is 0. Every pin configuration word reads 0x4, which means input disconnected and sensing off.
- R2: A pad value appears in the input register (address 0) two clocks after it is applied. A pin whose input is disconnected reads 0 there.
- R3: A pin configuration word has the sense code in bits [1:0] and the disconnect flag in bit 2. Sense code 2 watches for a high level, code 3 watches for a low level, and codes 0 and 1 disable sensing.
- R4: When mode is 0, `detect_o` is high in exactly the cycles in which at least one pin detect is high. A pin whose input already matches raises its detect in the cycle right after the configuration write, with no edge needed.
- R5: A pin detect that is high at a clock edge sets that pin's latch bit. The bit stays set after the detect falls.
- R6: Writing the latch register clears each bit written as 1, unless that pin's detect is high at the same edge. Bits written as 0 do not change.
- R7: When mode is 1, `detect_o` follows the latched detect. It is high when any latch bit is set and low once all latch bits are 0.
- R8: A latch write with a nonzero mask forces the latched detect low for the next clock. If any bit remains set, it is high again one clock later.
- R9: After a pin detect has been high, that pin can raise a new detect only after its synchronized input has been at the opposite level for 3 consecutive clocks. A shorter gap blocks detection until the input has been at the opposite level for 3 clocks again.
- R10: A pin whose input is disconnected never raises its detect, with either sense code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_PINS | Raw pad levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data for reg_addr |
| detect_o | output | 1 | Port-level detect |

## Verification
Directed sequences cover the cases that separate the detect rules from one another. One holds a matching level while a clear is written, which shows that the clear is blocked and the latched detect dips for one clock. Another pulses the opposite level for two clocks and then for three, which shows the re-arm window. A third enables a pin whose input already matches, which shows that detection needs no edge. Reads of the input register one clock and two clocks after a pad change locate the synchronizer delay. A run of random pad flips, configuration writes, latch clears and mode toggles is then compared every cycle against a reference model in the bench. This mix tells the two mode sources apart, and it tells disconnected pins apart from disabled ones.

// File: rtl/lvl_sense_pkg.sv
package lvl_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'd0,
    SENSE_RSVD = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  typedef struct packed {
    logic   disc;
    sense_e sense;
  } pin_cfg_t;

  localparam int unsigned CFG_W       = $bits(pin_cfg_t);
  localparam int unsigned REG_IN      = 0;
  localparam int unsigned REG_LATCH   = 1;
  localparam int unsigned REG_MODE    = 2;
  localparam pin_cfg_t    CFG_RESET   = '{disc: 1'b1, sense: SENSE_OFF};

endpackage

// File: rtl/lvl_sense_sync.sv
module lvl_sense_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lvl_sense_pin.sv
module lvl_sense_pin
  import lvl_sense_pkg::*;
#(
  parameter int unsigned REARM = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_i,
  input  pin_cfg_t cfg_i,
  output logic     det_o
);

  localparam int unsigned CW = $clog2(REARM + 1);
  localparam logic [CW-1:0] FULL = CW'(REARM);

  logic [CW-1:0] quiet_q, quiet_d;
  logic          det_q;
  logic          match;
  logic          armed;

  always_comb begin
    match = 1'b0;
    if (!cfg_i.disc) begin
      unique case (cfg_i.sense)
        SENSE_HIGH: match = in_i;
        SENSE_LOW:  match = !in_i;
        default:    match = 1'b0;
      endcase
    end
  end

  assign armed = (quiet_q == FULL);
  assign det_o = match && (armed || det_q);

  always_comb begin
    if (match)      quiet_d = '0;
    else if (armed) quiet_d = quiet_q;
    else            quiet_d = quiet_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= FULL;
      det_q   <= 1'b0;
    end else begin
      quiet_q <= quiet_d;
      det_q   <= det_o;
    end
  end

endmodule

// File: rtl/lvl_sense_latch.sv
module lvl_sense_latch #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_det_i,
  input  logic                clr_en_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] latch_o,
  output logic                ldet_o
);

  logic [NUM_PINS-1:0] latch_q, latch_d, clr_eff;
  logic                ldet_q, ldet_d;

  always_comb begin
    clr_eff = clr_en_i ? clr_mask_i : '0;
    latch_d = (latch_q & ~clr_eff) | pin_det_i;
    ldet_d  = clr_en_i ? 1'b0 : (|latch_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      ldet_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      ldet_q  <= ldet_d;
    end
  end

  assign latch_o = latch_q;
  assign ldet_o  = ldet_q;

endmodule

// File: rtl/lvl_sense_port.sv
module lvl_sense_port
  import lvl_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REARM       = 3,
  parameter int unsigned ADDR_W      = $clog2(NUM_PINS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  output logic                detect_o
);

  localparam int unsigned IDX_W = ADDR_W - 1;

  logic [NUM_PINS-1:0] sync_in;
  logic [NUM_PINS-1:0] in_val;
  logic [NUM_PINS-1:0] pin_det;
  logic [NUM_PINS-1:0] cfg_disc;
  logic [NUM_PINS-1:0] latch_q;
  logic                ldet_q;
  logic                mode_q, mode_d, mode_en;
  logic                cfg_sel;
  logic [IDX_W-1:0]    idx;
  logic                glb_we, lat_clr;
  pin_cfg_t            cfg_q [NUM_PINS];

  assign cfg_sel = reg_addr[ADDR_W-1];
  assign idx     = reg_addr[IDX_W-1:0];
  assign glb_we  = reg_we && !cfg_sel;
  assign lat_clr = glb_we && (idx == IDX_W'(REG_LATCH)) && (|reg_wdata);

  lvl_sense_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_i),
    .q_o   (sync_in)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pin_cfg_t cfg_d;
      logic     cfg_en;

      assign cfg_en = reg_we && cfg_sel && (idx == IDX_W'(p));
      assign cfg_d  = pin_cfg_t'(reg_wdata[CFG_W-1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q[p] <= CFG_RESET;
        else if (cfg_en) cfg_q[p] <= cfg_d;
      end

      assign cfg_disc[p] = cfg_q[p].disc;
      assign in_val[p]   = sync_in[p] && !cfg_q[p].disc;

      lvl_sense_pin #(.REARM(REARM)) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (sync_in[p]),
        .cfg_i (cfg_q[p]),
        .det_o (pin_det[p])
      );
    end
  endgenerate

  lvl_sense_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_det_i  (pin_det),
    .clr_en_i   (lat_clr),
    .clr_mask_i (reg_wdata),
    .latch_o    (latch_q),
    .ldet_o     (ldet_q)
  );

  assign mode_en = glb_we && (idx == IDX_W'(REG_MODE));
  assign mode_d  = reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (cfg_sel) begin
      if (32'(idx) < NUM_PINS) reg_rdata[CFG_W-1:0] = cfg_q[idx];
    end else begin
      case (32'(idx))
        REG_IN:    reg_rdata = in_val;
        REG_LATCH: reg_rdata = latch_q;
        REG_MODE:  reg_rdata[0] = mode_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign detect_o = mode_q ? ldet_q : (|pin_det);

endmodule

// File: rtl/lvl_sense_chk.sv
module lvl_sense_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [NUM_PINS-1:0] reg_wdata,
  input logic [NUM_PINS-1:0] pin_det,
  input logic [NUM_PINS-1:0] cfg_disc,
  input logic [NUM_PINS-1:0] latch_q,
  input logic                ldet_q,
  input logic                mode_q,
  input logic                detect_o
);

  logic clr;
  assign clr = reg_we && (reg_addr == ADDR_W'(lvl_sense_pkg::REG_LATCH)) && (|reg_wdata);

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(pin_det)) == $past(pin_det))); // R5

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((latch_q & $past(latch_q)) == $past(latch_q))); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((latch_q & $past(reg_wdata) & ~$past(pin_det)) == '0)); // R6

  AST_CLEAR_DIP: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ldet_q); // R8

  AST_LATCHED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && detect_o) |-> (latch_q != '0)); // R7

  AST_DEFAULT_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && (|pin_det)) |-> detect_o); // R4

  AST_DISC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_det & cfg_disc) == '0); // R10

endmodule

bind lvl_sense_port lvl_sense_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pin_det   (pin_det),
  .cfg_disc  (cfg_disc),
  .latch_q   (latch_q),
  .ldet_q    (ldet_q),
  .mode_q    (mode_q),
  .detect_o  (detect_o)
);

// File: tb/lvl_sense_port_tb.sv
module lvl_sense_port_tb;

  localparam int NP = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pad;
  logic          we;
  logic [AW-1:0] addr;
  logic [NP-1:0] wdata;
  logic [NP-1:0] rdata;
  logic          det;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  lvl_sense_port u_dut (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .detect_o(det)
  );

  // ---------------- reference model ----------------
  logic [NP-1:0] m_s1, m_s2, m_disc, m_detq, m_latch;
  logic [1:0]    m_sense [NP];
  int            m_cnt   [NP];
  logic          m_ldet, m_mode;

  function automatic logic m_match(int i);
    if (m_disc[i]) return 1'b0;
    if (m_sense[i] == 2'd2) return m_s2[i];
    if (m_sense[i] == 2'd3) return !m_s2[i];
    return 1'b0;
  endfunction

  function automatic logic [NP-1:0] m_detv();
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = m_match(i) && (m_cnt[i] == 3 || m_detq[i]);
    return v;
  endfunction

  function automatic logic m_detect();
    return m_mode ? m_ldet : (|m_detv());
  endfunction

  function automatic logic [NP-1:0] m_read(logic [AW-1:0] a);
    logic [NP-1:0] r = '0;
    if (a[AW-1]) r[2:0] = {m_disc[a[4:0]], m_sense[a[4:0]]};
    else if (a == 0) r = m_s2 & ~m_disc;
    else if (a == 1) r = m_latch;
    else if (a == 2) r[0] = m_mode;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_disc <= '1; m_detq <= '0; m_latch <= '0;
      m_ldet <= 1'b0; m_mode <= 1'b0;
      for (int i = 0; i < NP; i++) begin m_sense[i] <= 2'd0; m_cnt[i] <= 3; end
    end else begin
      logic [NP-1:0] dv, ln;
      logic clr;
      dv  = m_detv();
      clr = we && addr == 1 && |wdata;
      ln  = (m_latch & ~(clr ? wdata : '0)) | dv;
      m_latch <= ln;
      m_ldet  <= clr ? 1'b0 : |ln;
      for (int i = 0; i < NP; i++) begin
        m_cnt[i] <= m_match(i) ? 0 : (m_cnt[i] == 3 ? 3 : m_cnt[i] + 1);
      end
      m_detq <= dv;
      if (we && addr[AW-1]) begin
        m_sense[addr[4:0]] <= wdata[1:0];
        m_disc[addr[4:0]]  <= wdata[2];
      end
      if (we && addr == 2) m_mode <= wdata[0];
      m_s2 <= m_s1;
      m_s1 <= pad;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NP-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [NP-1:0] d);
    addr = a; #1ns; d = rdata;
  endtask

  task automatic chk_rd(logic [AW-1:0] a, logic [NP-1:0] exp, string req);
    logic [NP-1:0] v;
    rd(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic chk_det(logic exp, string req);
    check(det === exp, req, {31'd0, det}, {31'd0, exp});
  endtask

  initial begin
    #800000ns;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] v;
    int unsigned seed;
    rst_n = 1'b0; pad = '0; we = 1'b0; addr = '0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk_rd(1, '0, "R1 latch");
    chk_rd(2, '0, "R1 mode");
    chk_rd(6'd32, 32'h4, "R1 cfg0");
    chk_rd(6'd63, 32'h4, "R1 cfg31");
    chk_det(1'b0, "R1 detect");

    // R2/R3/R10: pin 3 sense high connected, others disconnected
    wr(6'd35, 32'h2);
    chk_rd(6'd35, 32'h2, "R3 cfg readback");
    pad = 32'hFFFF_FFFF;
    tick();
    chk_rd(0, '0, "R2 one clock not yet");
    chk_det(1'b0, "R2 detect not yet");
    tick();
    chk_rd(0, 32'h8, "R2 two clocks, R10 disconnected read 0");
    chk_det(1'b1, "R4 OR of detects");
    tick();
    chk_rd(1, 32'h8, "R5 latch set");

    // R6 clear blocked while detecting
    wr(1, 32'h8);
    chk_rd(1, 32'h8, "R6 clear blocked");
    pad = '0;
    tick(3);
    chk_det(1'b0, "R4 detect falls");
    chk_rd(1, 32'h8, "R5 sticky after fall");
    wr(1, 32'h0);
    chk_rd(1, 32'h8, "R6 zero write no effect");
    wr(1, 32'h8);
    chk_rd(1, 32'h0, "R6 clear works");

    // R3/R4 sense low with immediate enable; R10 disconnected low sense
    wr(6'd40, 32'h7);
    chk_det(1'b0, "R10 disconnected low sense");
    wr(6'd37, 32'h3);
    chk_det(1'b1, "R4 immediate on enable low");
    wr(6'd37, 32'h1);
    chk_det(1'b0, "R3 code 1 disabled");
    wr(6'd37, 32'h0);
    chk_det(1'b0, "R3 code 0 disabled");
    wr(1, 32'hFFFF_FFFF);
    chk_rd(1, 32'h0, "R6 clear all");

    // R7/R8 latched mode
    wr(2, 32'h1);
    chk_rd(2, 32'h1, "R7 mode readback");
    pad[3] = 1'b1;
    tick(2);
    chk_det(1'b0, "R7 latched lags raw");
    tick();
    chk_det(1'b1, "R7 latched high");
    wr(1, 32'h8);
    chk_det(1'b0, "R8 dip after clear with survivor");
    tick();
    chk_det(1'b1, "R8 rises again");
    pad[3] = 1'b0;
    tick(4);
    chk_det(1'b1, "R7 stays latched");
    wr(1, 32'h8);
    chk_det(1'b0, "R7 low after full clear");
    tick();
    chk_det(1'b0, "R7 stays low");
    wr(2, 32'h0);

    // R9 re-arm window
    pad[3] = 1'b1;
    tick(2);
    chk_det(1'b1, "R9 first detect");
    pad[3] = 1'b0;
    tick(2);
    pad[3] = 1'b1;
    tick(2);
    chk_det(1'b0, "R9 two-clock gap blocked");
    tick(3);
    chk_det(1'b0, "R9 still blocked");
    pad[3] = 1'b0;
    tick(3);
    pad[3] = 1'b1;
    tick(2);
    chk_det(1'b1, "R9 three-clock gap re-arms");
    pad[3] = 1'b0;
    tick(4);
    wr(1, '1);

    // random phase against model
    seed = $urandom(32'h5EED_0042);
    for (int c = 0; c < 4000; c++) begin
      int unsigned r = $urandom() % 32;
      chk_det(m_detect(), "R4 R7 random detect");
      if ($urandom() % 4 == 0) pad[$urandom() % 8] = ~pad[$urandom() % 8];
      if (r < 4) begin
        we = 1; addr = {1'b1, 5'($urandom() % 8)}; wdata = 32'($urandom() % 8);
      end else if (r < 8) begin
        we = 1; addr = 1; wdata = 32'($urandom() % 256);
      end else if (r == 8) begin
        we = 1; addr = 2; wdata = 32'($urandom() % 2);
      end else begin
        logic [AW-1:0] a;
        we = 0; wdata = '0;
        a = (r < 20) ? AW'(r % 3) : {1'b1, 5'($urandom() % 32)};
        rd(a, v);
        check(v === m_read(a), "R2 R3 R5 R6 random read", v, m_read(a));
      end
      tick();
      we = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule